// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters on a multidrop line. Each bit period is split into sixteen sample ticks. A start bit counts only if the line is still low at the middle of that bit. Each data bit is then taken at its centre, least significant bit first. The block handles 8 or 9 data bits and one stop bit.

Software can put the receiver into standby. In standby, incoming characters reach neither the data register nor the data-ready flag. Standby ends by itself, and the event that ends it depends on a wake-method input:

- With wake-method 0, a line idle event ends standby.
- With wake-method 1, a 9-bit character whose top bit is 1 (an address mark) ends standby. That character is delivered.

An idle event means ten bit times of continuous high line after a character. The idle flag is raised once for each idle period. It is raised again only after a new character or a break has come in. That is why software reads the active flag before it arms idle wakeup. The enable readback stays high while a character is still arriving after the enable has been dropped.

Top module: `uart_wake_rx`

## Requirements
- R1: With `rx_en` high, a falling edge starts a character. The character is received only if the line is still low eight ticks later (mid start bit). Data bits are sampled every sixteen ticks after that, least significant first: 8 bits when `nine_bit` is 0 and 9 bits when it is 1. A character whose stop bit is high sets `data_ready` and loads `rx_data`, with bit 8 equal to 0 in 8-bit mode. A low pulse shorter than half a bit starts nothing. `data_ack` clears `data_ready`.
- R2: A character whose stop bit is low is not delivered. This includes a break, where the start, data and stop bits are all low.
- R3: A pulse on `standby_set` sets `standby`. While `standby` is 1, received characters leave `data_ready` and `rx_data` unchanged, unless R5 applies.
- R4: With `wake_sel` = 0, `standby` clears at the idle event.
- R5: With `wake_sel` = 1 and `mark_block` = 0, a 9-bit character with bit 8 = 1 clears `standby` and is delivered. A character with bit 8 = 0 does not clear it, and neither does an idle event.
- R6: With `mark_block` = 1, an address-mark character leaves `standby` set and is not delivered. A pulse on `standby_clr` clears `standby`.
- R7: After a received character, `idle_flag` sets once the line has been high for 10 bit times (160 ticks) with `rx_en` high. `idle_ack` clears it.
- R8: After an idle event, `idle_flag` does not set again until a character with a good stop bit, or a break, has been received. No idle event occurs between reset and the first such character.
- R9: `active` is 1 from the detected start edge until the stop bit has been sampled.
- R10: `en_status` equals `rx_en` OR `active`. A character in progress when `rx_en` falls is completed and delivered. No new character starts while `rx_en` is 0.
- R11: `irq` equals (`data_ready` AND `rdy_ie`) OR (`idle_flag` AND `idle_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, asynchronous |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9 data bits |
| wake_sel | input | 1 | 0: idle wakeup, 1: address-mark wakeup |
| mark_block | input | 1 | 1 stops address marks from ending standby |
| standby_set | input | 1 | Pulse: enter standby |
| standby_clr | input | 1 | Pulse: leave standby |
| data_ack | input | 1 | Pulse: clear data_ready |
| idle_ack | input | 1 | Pulse: clear idle_flag |
| rdy_ie | input | 1 | Interrupt enable for data_ready |
| idle_ie | input | 1 | Interrupt enable for idle_flag |
| rx_data | output | 9 | Last delivered character |
| data_ready | output | 1 | A character is waiting |
| idle_flag | output | 1 | Idle event seen |
| active | output | 1 | Character reception in progress |
| en_status | output | 1 | Enable readback |
| standby | output | 1 | Standby state |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arming bit for idle detection shows at the ports within eleven bit times. Either a second `idle_flag` appears with no traffic in between, or the expected one never comes. A standby state that clears at the wrong event shows on the next character: `rx_data` or `data_ready` changes when it should stay put, or stays put when it should change. A bit counter or sample phase that is off shows as corrupted data at the end of the same frame. The enable readback and the interrupt line are compared against the other ports on every clock, so an error there shows within one cycle.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

    localparam int CHAR_W = 9;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              stop_ok;
        logic              is_break;
    } rx_char_t;

    function automatic logic is_addr_mark(rx_char_t c, logic nine);
        return c.stop_ok & nine & c.data[CHAR_W-1];
    endfunction

    function automatic logic [3:0] last_bit_idx(logic nine);
        return nine ? 4'd8 : 4'd7;
    endfunction

endpackage

// File: rtl/uwr_tick_gen.sv
module uwr_tick_gen #(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CLKS_PER_TICK <= 1) begin : g_direct
            logic unused_in;
            assign unused_in = clk ^ rst;
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(CLKS_PER_TICK);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == CW'(CLKS_PER_TICK - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = (cnt == CW'(CLKS_PER_TICK - 1));
        end
    endgenerate
endmodule

// File: rtl/uwr_bit_rx.sv
module uwr_bit_rx
    import uart_wake_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd_s,
    input  logic     enable,
    input  logic     nine_bit,
    output logic     busy,
    output logic     char_evt,
    output rx_char_t ch
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e         state;
    logic [CW-1:0]     os_cnt;
    logic [3:0]        bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            os_cnt   <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            prev     <= 1'b1;
            char_evt <= 1'b0;
            ch       <= '0;
        end else begin
            char_evt <= 1'b0;
            prev     <= rxd_s;
            case (state)
                RX_IDLE: begin
                    if (enable && prev && !rxd_s) begin
                        state  <= RX_START;
                        os_cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (os_cnt == MID) begin
                            os_cnt <= '0;
                            if (!rxd_s) begin
                                state   <= RX_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (os_cnt == LAST) begin
                            os_cnt         <= '0;
                            shreg[bit_idx] <= rxd_s;
                            bit_idx        <= bit_idx + 1'b1;
                            if (bit_idx == last_bit_idx(nine_bit)) begin
                                state <= RX_STOP;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (os_cnt == LAST) begin
                            state       <= RX_IDLE;
                            os_cnt      <= '0;
                            char_evt    <= 1'b1;
                            ch.data     <= shreg;
                            ch.stop_ok  <= rxd_s;
                            ch.is_break <= !rxd_s && (shreg == '0);
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign busy = (state != RX_IDLE);

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && !enable) |=> (state == RX_IDLE)); // R10
    AST_CHAR_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        char_evt |-> ($past(state) == RX_STOP && state == RX_IDLE)); // R1
    AST_STOP_CLASS: assert property (@(posedge clk) disable iff (rst)
        char_evt |-> !(ch.stop_ok && ch.is_break)); // R2
endmodule

// File: rtl/uwr_wake_ctrl.sv
module uwr_wake_ctrl
    import uart_wake_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int IDLE_BITS = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     enable,
    input  logic     rxd_s,
    input  logic     busy,
    input  logic     char_evt,
    input  rx_char_t ch,
    input  logic     nine_bit,
    input  logic     wake_sel,
    input  logic     mark_block,
    input  logic     standby_set,
    input  logic     standby_clr,
    output logic     standby,
    output logic     deliver,
    output logic     idle_evt
);
    localparam int IDLE_TICKS = OVS * IDLE_BITS;
    localparam int IW = $clog2(IDLE_TICKS);

    logic [IW-1:0] idle_cnt;
    logic          idle_armed;
    logic          idle_hit;
    logic          line_quiet;
    logic          mark;
    logic          wake_mark;

    assign line_quiet = enable && !busy && rxd_s;
    assign idle_hit   = line_quiet && tick && idle_armed &&
                        (idle_cnt == IW'(IDLE_TICKS - 1));
    assign mark       = is_addr_mark(ch, nine_bit);
    assign wake_mark  = char_evt && mark && wake_sel && !mark_block;
    assign deliver    = char_evt && ch.stop_ok && (!standby || wake_mark);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt   <= '0;
            idle_armed <= 1'b0;
            idle_evt   <= 1'b0;
            standby    <= 1'b0;
        end else begin
            idle_evt <= idle_hit;
            if (!line_quiet || !idle_armed) begin
                idle_cnt <= '0;
            end else if (tick) begin
                idle_cnt <= idle_hit ? '0 : idle_cnt + 1'b1;
            end
            if (char_evt && (ch.stop_ok || ch.is_break)) begin
                idle_armed <= 1'b1;
            end else if (idle_hit) begin
                idle_armed <= 1'b0;
            end
            if (standby_set) begin
                standby <= 1'b1;
            end else if (standby_clr || wake_mark || (idle_hit && !wake_sel)) begin
                standby <= 1'b0;
            end
        end
    end

    AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (!idle_armed && !char_evt) |=> !idle_evt); // R8
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
        (idle_hit && !wake_sel && !standby_set) |=> !standby); // R4
    AST_STANDBY_MUTE: assert property (@(posedge clk) disable iff (rst)
        (standby && char_evt && !(wake_sel && !mark_block && mark)) |-> !deliver); // R3
    AST_MARK_WAKE: assert property (@(posedge clk) disable iff (rst)
        (standby && wake_mark && !standby_set) |=> !standby); // R5
    AST_MARK_HELD: assert property (@(posedge clk) disable iff (rst)
        (standby && mark_block && !standby_set && !standby_clr && !idle_hit) |=> standby); // R6
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_pkg::*;
#(
    parameter int OVS           = 16,
    parameter int CLKS_PER_TICK = 4,
    parameter int IDLE_BITS     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              wake_sel,
    input  logic              mark_block,
    input  logic              standby_set,
    input  logic              standby_clr,
    input  logic              data_ack,
    input  logic              idle_ack,
    input  logic              rdy_ie,
    input  logic              idle_ie,
    output logic [CHAR_W-1:0] rx_data,
    output logic              data_ready,
    output logic              idle_flag,
    output logic              active,
    output logic              en_status,
    output logic              standby,
    output logic              irq
);
    logic [1:0] sync;
    logic       rxd_s;
    logic       tick;
    logic       busy;
    logic       char_evt;
    rx_char_t   ch;
    logic       deliver;
    logic       idle_evt;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end
    assign rxd_s = sync[1];

    uwr_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    uwr_bit_rx #(.OVS(OVS)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rxd_s    (rxd_s),
        .enable   (rx_en),
        .nine_bit (nine_bit),
        .busy     (busy),
        .char_evt (char_evt),
        .ch       (ch)
    );

    uwr_wake_ctrl #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_wake (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .enable      (rx_en),
        .rxd_s       (rxd_s),
        .busy        (busy),
        .char_evt    (char_evt),
        .ch          (ch),
        .nine_bit    (nine_bit),
        .wake_sel    (wake_sel),
        .mark_block  (mark_block),
        .standby_set (standby_set),
        .standby_clr (standby_clr),
        .standby     (standby),
        .deliver     (deliver),
        .idle_evt    (idle_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            idle_flag  <= 1'b0;
        end else begin
            if (deliver) begin
                rx_data    <= ch.data;
                data_ready <= 1'b1;
            end else if (data_ack) begin
                data_ready <= 1'b0;
            end
            if (idle_evt)      idle_flag <= 1'b1;
            else if (idle_ack) idle_flag <= 1'b0;
        end
    end

    assign active    = busy;
    assign en_status = rx_en | busy;
    assign irq       = (data_ready & rdy_ie) | (idle_flag & idle_ie);

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (data_ready && !data_ack) |=> data_ready); // R1
    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!char_evt) |=> $stable(rx_data)); // R3
    AST_BREAK_DROP: assert property (@(posedge clk) disable iff (rst)
        (char_evt && !ch.stop_ok && !data_ready) |=> !data_ready); // R2
endmodule

// File: tb/uart_wake_rx_test.sv
module uart_wake_rx_test;
    localparam int CLK_P = 10;
    localparam int OVS   = 16;
    localparam int CPT   = 4;
    localparam int BIT   = OVS * CPT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0, nine_bit = 1'b0, wake_sel = 1'b0, mark_block = 1'b0;
    logic       standby_set = 1'b0, standby_clr = 1'b0, data_ack = 1'b0, idle_ack = 1'b0;
    logic       rdy_ie = 1'b1, idle_ie = 1'b0;
    logic [8:0] rx_data;
    logic       data_ready, idle_flag, active, en_status, standby, irq;

    int tests = 0;
    int fails = 0;
    logic [8:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    uart_wake_rx #(.OVS(OVS), .CLKS_PER_TICK(CPT), .IDLE_BITS(10)) uut (
        .clk(clk), .rst(rst), .rxd(rxd), .rx_en(rx_en), .nine_bit(nine_bit),
        .wake_sel(wake_sel), .mark_block(mark_block), .standby_set(standby_set),
        .standby_clr(standby_clr), .data_ack(data_ack), .idle_ack(idle_ack),
        .rdy_ie(rdy_ie), .idle_ie(idle_ie), .rx_data(rx_data), .data_ready(data_ready),
        .idle_flag(idle_flag), .active(active), .en_status(en_status),
        .standby(standby), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; wait_clk(1); sig = 1'b0;
    endtask

    // drop_bit >= 0 drops rx_en in the middle of that data bit
    task automatic send_frame(input logic [8:0] d, input int nb, input logic stop_v, input int drop_bit);
        rxd = 1'b0; wait_clk(BIT);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            if (i == drop_bit) begin
                wait_clk(BIT/2);
                rx_en = 1'b0;
                wait_clk(1);
                check("R10 readback held mid-char", en_status, 1);
                check("R9 active mid-char", active, 1);
                wait_clk(BIT/2 - 1);
            end else begin
                wait_clk(BIT);
            end
        end
        rxd = stop_v; wait_clk(BIT);
        rxd = 1'b1; wait_clk(2);
    endtask

    task automatic expect_rx(input string req);
        logic [8:0] e;
        e = exp_q.pop_front();
        check({req, " ready"}, data_ready, 1);
        check({req, " data"}, rx_data, e);
        pulse(data_ack);
        check("R1 ack clears ready", data_ready, 0);
    endtask

    task automatic idle_cycle(input string req);
        wait_clk(11*BIT);
        check(req, idle_flag, 1);
        pulse(idle_ack);
        check("R7 ack clears idle", idle_flag, 0);
    endtask

    // per-clock comparison of combinational relations, sampled mid-cycle
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!rst) begin
            check("R11 irq", irq, (data_ready & rdy_ie) | (idle_flag & idle_ie));
            check("R10 en_status", en_status, rx_en | active);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);
        check("R1 reset ready", data_ready, 0);
        check("R7 reset idle", idle_flag, 0);
        check("R9 reset active", active, 0);
        check("R3 reset standby", standby, 0);
        check("R10 reset en_status", en_status, 0);

        // disabled receiver ignores a frame
        send_frame(9'h0F0, 8, 1'b1, -1);
        check("R10 no receive while disabled", data_ready, 0);

        rx_en = 1'b1;
        wait_clk(12*BIT);
        check("R8 no idle before first char", idle_flag, 0);

        // short glitch is not a start
        rxd = 1'b0; wait_clk(16); rxd = 1'b1; wait_clk(2*BIT);
        check("R1 glitch ignored ready", data_ready, 0);
        check("R9 glitch not active", active, 0);

        exp_q.push_back(9'h0A5);
        send_frame(9'h0A5, 8, 1'b1, -1);
        check("R9 inactive after char", active, 0);
        expect_rx("R1 8-bit A5");

        wait_clk(8*BIT);
        check("R7 idle not before 10 bits", idle_flag, 0);
        idle_ie = 1'b1;
        wait_clk(3*BIT);
        check("R7 idle after 10 bits", idle_flag, 1);
        check("R11 irq from idle", irq, 1);
        pulse(idle_ack);
        wait_clk(12*BIT);
        check("R8 idle not reasserted", idle_flag, 0);

        rdy_ie = 1'b0;
        exp_q.push_back(9'h03C);
        send_frame(9'h03C, 8, 1'b1, -1);
        check("R11 irq masked", irq, 0);
        expect_rx("R1 8-bit 3C");
        idle_cycle("R8 idle rearmed by char");
        rdy_ie = 1'b1;

        // standby with idle wake
        wait_clk(1); pulse(standby_set);
        check("R3 standby set", standby, 1);
        send_frame(9'h011, 8, 1'b1, -1);
        check("R3 standby no ready", data_ready, 0);
        check("R3 standby data kept", rx_data, 9'h03C);
        check("R4 still in standby", standby, 1);
        idle_cycle("R4 idle event");
        check("R4 idle ended standby", standby, 0);
        exp_q.push_back(9'h022);
        send_frame(9'h022, 8, 1'b1, -1);
        expect_rx("R4 after wake");
        idle_cycle("R7 idle");

        // address-mark wake
        nine_bit = 1'b1; wake_sel = 1'b1;
        pulse(standby_set);
        send_frame(9'h055, 9, 1'b1, -1);
        check("R5 non-mark kept out", data_ready, 0);
        idle_cycle("R7 idle in standby");
        check("R5 idle does not wake", standby, 1);
        exp_q.push_back(9'h1AB);
        send_frame(9'h1AB, 9, 1'b1, -1);
        check("R5 mark wakes", standby, 0);
        expect_rx("R5 mark delivered");
        idle_cycle("R7 idle");

        // mark blocked
        mark_block = 1'b1;
        pulse(standby_set);
        send_frame(9'h1CD, 9, 1'b1, -1);
        check("R6 blocked mark stays standby", standby, 1);
        check("R6 blocked mark not delivered", data_ready, 0);
        pulse(standby_clr);
        check("R6 standby_clr", standby, 0);
        mark_block = 1'b0; wake_sel = 1'b0; nine_bit = 1'b0;
        idle_cycle("R7 idle");

        // break and framing error
        send_frame(9'h000, 8, 1'b0, -1);
        check("R2 break not delivered", data_ready, 0);
        idle_cycle("R8 idle rearmed by break");
        send_frame(9'h05A, 8, 1'b0, -1);
        check("R2 bad stop not delivered", data_ready, 0);
        wait_clk(12*BIT);
        check("R8 bad stop does not rearm", idle_flag, 0);

        // enable dropped mid character
        exp_q.push_back(9'h0C3);
        send_frame(9'h0C3, 8, 1'b1, 3);
        check("R10 readback low after char", en_status, 0);
        expect_rx("R10 char completed");
        rx_en = 1'b1;
        idle_cycle("R7 idle after reenable");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule